// File: doc/BRIEF.md
# Multiplexed SAR Converter Host Sequencer

This block drives an external 8-channel, 12-bit successive-approximation converter. The converter has a serial port and a separate conversion-start pin. A client presents a request with a channel number and three flags: differential input, bipolar coding and sleep. When the block is ready it accepts the request, raises the start pin for a fixed conversion time and then runs one serial frame of 12 clocks.

During that frame the block sends the 6-bit setup word for the following sample and collects the 12-bit result of the sample just converted. Frames are pipelined, so the data read back always belongs to the setup sent one frame earlier. The block therefore keeps that earlier setup as a tag and returns it beside the data with a one-cycle valid strobe. The data bits are passed through unchanged. The bipolar flag in the tag says whether they are two's complement (bipolar) or straight binary (unipolar).

After a setup word has been sent, the block holds off the next start edge until a minimum acquisition time has elapsed. The serial clock rate, the conversion time and the acquisition time are all parameters counted in system clocks.

Top module: `adc_seq_host`

## Requirements
- R1: After reset, `cnv_start`, `sck`, `sdi` and `res_valid` are low and `req_ready` is high.
- R2: The setup word goes out first bit first. In sending order it is: single-ended (1 = single-ended, i.e. not `req_diff`), `req_chan[0]`, `req_chan[2]`, `req_chan[1]`, unipolar (1 = not `req_bipolar`), `req_sleep`.
- R3: An accepted request raises `cnv_start` for exactly CONV_CYCLES clocks, starting the clock after acceptance. Only one rising edge of `cnv_start` occurs per request.
- R4: Each frame has exactly 12 `sck` pulses. Each pulse is high for SCK_HALF clocks. `sck` stays low while idle and while `cnv_start` is high.
- R5: `sdi` changes only while `sck` is low, so it is stable across every `sck` high phase. After the sixth bit it is 0.
- R6: `sdo` is sampled on each rising `sck` edge. The first sample is the most significant bit of `res_data`.
- R7: A reported result carries the channel, differential flag and bipolar flag of the request whose setup word went out in the frame before.
- R8: The first frame after reset reports no result.
- R9: The frame that follows a frame with the sleep bit set reports no result.
- R10: A rising edge of `cnv_start` comes at least ACQ_CYCLES clocks after the sixth rising `sck` edge of the previous frame. `req_ready` stays low until then.
- R11: `res_valid` is a single-cycle pulse, at most one per frame.
- R12: A request presented while `req_ready` is low is ignored. It neither starts a conversion nor changes the setup word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_chan | input | 3 | Requested channel |
| req_diff | input | 1 | 1 = differential input pair |
| req_bipolar | input | 1 | 1 = bipolar (two's complement) coding |
| req_sleep | input | 1 | 1 = put converter to sleep after this setup |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| cnv_start | output | 1 | Conversion-start pin to converter |
| sck | output | 1 | Serial clock to converter |
| sdi | output | 1 | Setup bits to converter |
| sdo | input | 1 | Result bits from converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Raw result bits |
| res_chan | output | 3 | Channel tag of the result |
| res_diff | output | 1 | Differential tag of the result |
| res_bipolar | output | 1 | Coding tag of the result |

## Verification
The bench plays the converter. It records the setup word it receives and returns a result derived from that word. This exposes a design that pairs data with the wrong request's tag (R7), or swaps the order of the address bits (R2), as a data or tag mismatch. Sequences that include the first frame after reset and a frame following a sleep setup catch a design that reports stale data. Stray requests injected during a conversion catch a design that restarts `cnv_start` or replaces the pending setup. Continuous timing monitors catch a design that shortens the start pulse, changes `sdi` while `sck` is high, or starts the next conversion before the acquisition interval has elapsed.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CFG_W = 6;
    localparam int RES_W = 12;
    localparam int CH_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_FRAME
    } seq_state_t;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            diff;
        logic            bipolar;
        logic            sleep;
    } seq_req_t;

endpackage

// File: rtl/adc_seq_cfg_map.sv
module adc_seq_cfg_map
    import adc_seq_pkg::*;
(
    input  seq_req_t         req,
    output logic [CFG_W-1:0] word
);
    // Sending order, first bit at the top: single-ended, chan[0], chan[2],
    // chan[1], unipolar, sleep.
    always_comb begin
        word = {~req.diff, req.chan[0], req.chan[2], req.chan[1],
                ~req.bipolar, req.sleep};
    end
endmodule

// File: rtl/adc_seq_sck_gen.sv
module adc_seq_sck_gen #(
    parameter int SCK_HALF = 2,
    parameter int NBITS    = 12,
    parameter int MARK     = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise,
    output logic fall,
    output logic mark,
    output logic done
);
    localparam int CW = $clog2(SCK_HALF + 1);
    localparam int NW = $clog2(NBITS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sck;
        logic [NW-1:0] nrise;
    } gen_t;

    gen_t q, d;
    logic edge_now;

    always_comb begin
        edge_now = run && (q.cnt == CW'(SCK_HALF - 1));
        rise     = edge_now && !q.sck;
        fall     = edge_now && q.sck;
        mark     = rise && (q.nrise == NW'(MARK - 1));
        done     = fall && (q.nrise == NW'(NBITS));
        d = q;
        if (!run) begin
            d = '0;
        end else if (edge_now) begin
            d.cnt = '0;
            d.sck = ~q.sck;
            if (rise) d.nrise = q.nrise + 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck = q.sck;
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
    parameter int TX_W = 6,
    parameter int RX_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_word,
    input  logic            tx_step,
    input  logic            rx_step,
    input  logic            sdo,
    output logic            sdi,
    output logic [RX_W-1:0] rx_word
);
    typedef struct packed {
        logic [TX_W-1:0] tx;
        logic [RX_W-1:0] rx;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (load)         d.tx = load_word;
        else if (tx_step) d.tx = {q.tx[TX_W-2:0], 1'b0};
        if (rx_step)      d.rx = {q.rx[RX_W-2:0], sdo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdi     = q.tx[TX_W-1];
    assign rx_word = q.rx;
endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
    import adc_seq_pkg::*;
#(
    parameter int SCK_HALF    = 2,
    parameter int CONV_CYCLES = 200,
    parameter int ACQ_CYCLES  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CH_W-1:0]  req_chan,
    input  logic             req_diff,
    input  logic             req_bipolar,
    input  logic             req_sleep,
    output logic             req_ready,
    output logic             cnv_start,
    output logic             sck,
    output logic             sdi,
    input  logic             sdo,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic [CH_W-1:0]  res_chan,
    output logic             res_diff,
    output logic             res_bipolar
);
    localparam int TW = $clog2(CONV_CYCLES + 1);
    localparam int AW = $clog2(ACQ_CYCLES + 1);

    typedef struct packed {
        seq_state_t       state;
        logic [TW-1:0]    timer;
        logic [AW-1:0]    acq;
        logic             cnv;
        seq_req_t         pend;
        seq_req_t         tag;
        logic             tag_ok;
        seq_req_t         out_tag;
        logic             res_valid;
        logic [RES_W-1:0] res_data;
    } host_t;

    host_t q, d;

    seq_req_t         req_in;
    logic [CFG_W-1:0] cfg_word;
    logic             run, load, rise, fall, mark, done, accept;
    logic [RES_W-1:0] rx_word;

    assign req_in = '{chan: req_chan, diff: req_diff,
                      bipolar: req_bipolar, sleep: req_sleep};

    adc_seq_cfg_map u_map (
        .req  (q.pend),
        .word (cfg_word)
    );

    adc_seq_sck_gen #(
        .SCK_HALF (SCK_HALF),
        .NBITS    (RES_W),
        .MARK     (CFG_W)
    ) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sck   (sck),
        .rise  (rise),
        .fall  (fall),
        .mark  (mark),
        .done  (done)
    );

    adc_seq_shifter #(
        .TX_W (CFG_W),
        .RX_W (RES_W)
    ) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (cfg_word),
        .tx_step   (fall),
        .rx_step   (rise),
        .sdo       (sdo),
        .sdi       (sdi),
        .rx_word   (rx_word)
    );

    always_comb begin
        run       = (q.state == ST_FRAME);
        load      = (q.state == ST_CONV) && (q.timer == '0);
        req_ready = (q.state == ST_IDLE) && (q.acq == '0);
        accept    = req_valid && req_ready;

        d = q;
        d.res_valid = 1'b0;
        if (q.acq != '0) d.acq = q.acq - 1'b1;
        if (mark)        d.acq = AW'(ACQ_CYCLES);

        unique case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    d.state = ST_CONV;
                    d.cnv   = 1'b1;
                    d.timer = TW'(CONV_CYCLES - 1);
                    d.pend  = req_in;
                end
            end
            ST_CONV: begin
                if (q.timer == '0) begin
                    d.state = ST_FRAME;
                    d.cnv   = 1'b0;
                end else begin
                    d.timer = q.timer - 1'b1;
                end
            end
            ST_FRAME: begin
                if (done) begin
                    d.state = ST_IDLE;
                    if (q.tag_ok) begin
                        d.res_valid = 1'b1;
                        d.res_data  = rx_word;
                        d.out_tag   = q.tag;
                    end
                    d.tag    = q.pend;
                    d.tag_ok = !q.pend.sleep;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnv_start   = q.cnv;
    assign res_valid   = q.res_valid;
    assign res_data    = q.res_data;
    assign res_chan    = q.out_tag.chan;
    assign res_diff    = q.out_tag.diff;
    assign res_bipolar = q.out_tag.bipolar;
endmodule

// File: rtl/adc_seq_host_chk.sv
module adc_seq_host_chk #(
    parameter int CONV_CYCLES = 200
) (
    input logic clk,
    input logic rst_n,
    input logic cnv_start,
    input logic sck,
    input logic sdi,
    input logic req_ready,
    input logic res_valid
);
    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_cnt <= 0;
        else if (cnv_start) hi_cnt <= hi_cnt + 1;
        else                hi_cnt <= 0;
    end

    assert_cnv_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_start) |-> hi_cnt == CONV_CYCLES);

    assert_sck_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> !sck);

    assert_sdi_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdi));

    assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> !req_ready);

    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

bind adc_seq_host adc_seq_host_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv_start (cnv_start),
    .sck       (sck),
    .sdi       (sdi),
    .req_ready (req_ready),
    .res_valid (res_valid)
);

// File: tb/adc_seq_host_test.sv
module adc_seq_host_test;
    localparam int HALF = 2;
    localparam int CONV = 40;
    localparam int ACQ  = 30;
    localparam int NV   = 8;

    // {chan[2:0], diff, bipolar, sleep, expected setup word[5:0]}
    localparam logic [11:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b0, 1'b0, 6'b100010},
        {3'd5, 1'b1, 1'b1, 1'b0, 6'b011000},
        {3'd3, 1'b0, 1'b1, 1'b0, 6'b110100},
        {3'd6, 1'b0, 1'b0, 1'b1, 6'b101111},
        {3'd2, 1'b1, 1'b0, 1'b0, 6'b000110},
        {3'd7, 1'b0, 1'b1, 1'b0, 6'b111100},
        {3'd4, 1'b1, 1'b0, 1'b0, 6'b001010},
        {3'd1, 1'b0, 1'b0, 1'b0, 6'b110010}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_chan = '0;
    logic req_diff = 1'b0, req_bipolar = 1'b0, req_sleep = 1'b0;
    logic req_ready, cnv_start, sck, sdi, res_valid;
    logic sdo = 1'b0;
    logic [11:0] res_data;
    logic [2:0] res_chan;
    logic res_diff, res_bipolar;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    adc_seq_host #(.SCK_HALF(HALF), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_diff(req_diff), .req_bipolar(req_bipolar), .req_sleep(req_sleep),
        .req_ready(req_ready), .cnv_start(cnv_start), .sck(sck), .sdi(sdi),
        .sdo(sdo), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .res_diff(res_diff), .res_bipolar(res_bipolar)
    );

    function automatic logic [11:0] conv_val(input logic [5:0] c);
        return {c, c ^ 6'h2A};
    endfunction

    // Converter model and timing monitors, sampled between edges.
    logic p_cnv = 0, p_sck = 0, p_sdi = 0;
    logic [5:0] m_sh = '0, m_cfg = '0;
    logic [11:0] m_res = '0;
    int m_rises = 0, sck_hi = 0, cnv_len = 0, since6 = 0;
    bit since6_ok = 0;
    int n_cnv = 0, n_res = 0, r3_bad = 0, r4_bad = 0, r5_bad = 0, r10_bad = 0;
    logic [11:0] g_data = '0;
    logic [2:0] g_chan = '0;
    logic g_diff = 0, g_bip = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_cnv = 0; p_sck = 0; p_sdi = 0; m_rises = 0; sck_hi = 0;
            cnv_len = 0; since6_ok = 0; m_cfg = '0; sdo = 1'b0;
        end else begin
            if (since6_ok) since6++;
            if (cnv_start && !p_cnv) begin
                n_cnv++;
                if (since6_ok && since6 < ACQ) r10_bad++;
                m_res = conv_val(m_cfg);
                sdo = m_res[11];
                m_rises = 0;
            end
            if (cnv_start) cnv_len++;
            if (!cnv_start && p_cnv) begin
                if (cnv_len != CONV) r3_bad++;
                cnv_len = 0;
            end
            if (cnv_start && sck) r4_bad++;
            if (sck) sck_hi++;
            if (sck && !p_sck) begin
                if (m_rises < 6) m_sh = {m_sh[4:0], sdi};
                else if (sdi !== 1'b0) r5_bad++;
                m_rises++;
                if (m_rises == 6) begin
                    m_cfg = m_sh; since6 = 0; since6_ok = 1;
                end
            end
            if (!sck && p_sck) begin
                if (sck_hi != HALF) r4_bad++;
                sck_hi = 0;
                m_res = {m_res[10:0], 1'b0};
                sdo = m_res[11];
            end
            if (sck && p_sck && sdi !== p_sdi) r5_bad++;
            if (res_valid) begin
                n_res++;
                g_data = res_data; g_chan = res_chan;
                g_diff = res_diff; g_bip = res_bipolar;
            end
            p_cnv = cnv_start; p_sck = sck; p_sdi = sdi;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One transaction; prev_ok/prev_vec describe the setup sent the frame before.
    task automatic run_txn(input logic [11:0] v, input bit prev_ok,
                           input logic [11:0] prev_vec, input bit inject);
        int s_cnv, s_res, s3, s4, s5, s10;
        s_cnv = n_cnv; s_res = n_res; s3 = r3_bad; s4 = r4_bad;
        s5 = r5_bad; s10 = r10_bad;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_chan = v[11:9]; req_diff = v[8];
        req_bipolar = v[7]; req_sleep = v[6];
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_chan = ~v[11:9]; req_diff = ~v[8];
            req_bipolar = ~v[7]; req_sleep = 1'b1;
            repeat (5) @(negedge clk);
            req_valid = 1'b0;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        chk(m_cfg == v[5:0], "R2 setup word", m_cfg, v[5:0]);
        chk(n_cnv - s_cnv == 1, inject ? "R12 stray request" : "R3 start count",
            n_cnv - s_cnv, 1);
        chk(r3_bad == s3, "R3 start width", r3_bad - s3, 0);
        chk(r4_bad == s4 && m_rises == 12, "R4 sck pulses", m_rises, 12);
        chk(r5_bad == s5, "R5 sdi timing", r5_bad - s5, 0);
        chk(r10_bad == s10, "R10 acquisition", r10_bad - s10, 0);
        if (prev_ok) begin
            chk(n_res - s_res == 1, "R11 one strobe", n_res - s_res, 1);
            chk(g_data == conv_val(prev_vec[5:0]), "R6 result data", g_data,
                conv_val(prev_vec[5:0]));
            chk({g_chan, g_diff, g_bip} == prev_vec[11:7], "R7 tag",
                {g_chan, g_diff, g_bip}, prev_vec[11:7]);
        end else if (prev_vec[6]) begin
            chk(n_res == s_res, "R9 after sleep", n_res - s_res, 0);
        end else begin
            chk(n_res == s_res, "R8 first after reset", n_res - s_res, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit pok;
        logic [11:0] pv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cnv_start && !sck && !sdi && !res_valid && req_ready, "R1 reset state",
            {cnv_start, sck, sdi, res_valid, req_ready}, 5'b00001);
        pok = 0; pv = '0;
        for (int i = 0; i < NV; i++) begin
            run_txn(VEC[i], pok, pv, i == 2);
            pok = !VEC[i][6];
            pv  = VEC[i];
        end
        // Mid-stream reset: the next frame must report nothing (R8).
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !res_valid, "R1 ready after reset", req_ready, 1);
        run_txn(VEC[1], 1'b0, 12'd0, 1'b0);
        run_txn(VEC[2], 1'b1, VEC[1], 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule